// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational adder for two 16-bit operands and an incoming carry. The operands are split into four 4-bit groups. Inside each group, every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each carry in the group is then computed as one flat sum of products of those terms and the group's incoming carry. No carry passes from one bit to the next.

Each group also produces a group generate and a group propagate. A second lookahead stage has the same flat sum-of-products form as the first. It turns those group signals and the block carry-in into the carry into groups 1 to 3 and the final carry-out. No group's carry-out feeds another group's carry logic.

The block suits a datapath where the sum must settle within a few logic levels. It has no registers. The clock and reset that appear in the bench are used only to pace stimulus.

Top module: `cla_adder`

## Requirements
- R1: For all operands, {carry_out, sum_out} equals opnd_a + opnd_b + carry_in as an unsigned 17-bit result.
- R2: When every bit position propagates, for example opnd_a = 0xFFFF, opnd_b = 0x0000 and carry_in = 1, the sum is 0x0000 and carry_out is 1. With carry_in = 0, the same operands give 0xFFFF and carry_out 0.
- R3: A carry generated in bit 0 reaches carry_out through all higher propagating bits. For example, 0x0001 + 0xFFFF with carry_in = 0 gives 0x0000 with carry_out 1.
- R4: A carry generated inside one group crosses group boundaries through propagating groups. For example, 0x00F0 + 0x0010 gives 0x0100, and 0x0F00 + 0x0100 gives 0x1000.
- R5: When both operands are zero and carry_in is 0, the result is zero with no carry. When both operands are zero and carry_in is 1, the result is 0x0001.
- R6: The carry leaving each 4-bit group equals that group's generate, ORed with its propagate ANDed with the carry entering the group.
- R7: The largest operands with carry_in = 1 (0xFFFF + 0xFFFF + 1) give 0xFFFF with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First addend |
| opnd_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Each 4-bit group is swept through all 256 operand pairs with both carry-in values. The other groups are held first at all-propagate and then at all-kill, so the sweep separates a wrong group-internal carry term from a wrong group-level carry. Directed vectors force the longest carry paths: a pure carry-in chain, a carry generated at bit 0, and carries generated mid-word that have to cross whole groups. A long pseudo-random run covers mixed generate and propagate patterns. That run catches product terms that are missing or wrongly indexed, which only show up in combination.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned GRP_BITS = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_bit_t;

    function automatic pg_bit_t make_pg(input logic x, input logic y);
        pg_bit_t r;
        r.gen  = x & y;
        r.prop = x | y;
        return r;
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         c0_i,
    output logic [N:0]   carry_o,
    output logic         blk_gen_o,
    output logic         blk_prop_o
);

    // flat sum of products per carry: no carry feeds another carry
    always_comb begin
        carry_o[0] = c0_i;
        for (int i = 1; i <= N; i++) begin
            logic term;
            logic prod;
            term = 1'b0;
            for (int j = 0; j < i; j++) begin
                prod = gen_i[j];
                for (int k = j + 1; k < i; k++) prod = prod & prop_i[k];
                term = term | prod;
            end
            prod = c0_i;
            for (int k = 0; k < i; k++) prod = prod & prop_i[k];
            carry_o[i] = term | prod;
        end
    end

    always_comb begin
        logic t;
        logic pr;
        t = 1'b0;
        for (int j = 0; j < N; j++) begin
            pr = gen_i[j];
            for (int k = j + 1; k < N; k++) pr = pr & prop_i[k];
            t = t | pr;
        end
        blk_gen_o  = t;
        blk_prop_o = &prop_i;
    end

    always_comb begin
        if (!$isunknown({gen_i, prop_i, c0_i})) begin
            // R6
            blk_carry_chk: assert (carry_o[N] == (blk_gen_o | (blk_prop_o & c0_i)))
                else $error("block carry mismatch");
        end
    end

endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned N = GRP_BITS
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    pg_bit_t [N-1:0] pg;
    logic    [N-1:0] g_v;
    logic    [N-1:0] p_v;
    logic    [N:0]   c_v;

    for (genvar i = 0; i < N; i++) begin : g_bits
        assign pg[i]  = make_pg(a_i[i], b_i[i]);
        assign g_v[i] = pg[i].gen;
        assign p_v[i] = pg[i].prop;
    end

    cla_lookahead #(.N(N)) bit_la_i (
        .gen_i      (g_v),
        .prop_i     (p_v),
        .c0_i       (cin_i),
        .carry_o    (c_v),
        .blk_gen_o  (grp_gen_o),
        .blk_prop_o (grp_prop_o)
    );

    assign sum_o = a_i ^ b_i ^ c_v[N-1:0];

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R1
            grp_sum_chk: assert ({c_v[N], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (N+1)'(cin_i)))
                else $error("group sum mismatch");
        end
    end

endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int unsigned NGRP = WIDTH / GRP_BITS;

    logic [NGRP-1:0] grp_g;
    logic [NGRP-1:0] grp_p;
    logic [NGRP:0]   grp_c;
    logic            top_g;
    logic            top_p;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group #(.N(GRP_BITS)) grp_i (
            .a_i        (opnd_a[k*GRP_BITS +: GRP_BITS]),
            .b_i        (opnd_b[k*GRP_BITS +: GRP_BITS]),
            .cin_i      (grp_c[k]),
            .sum_o      (sum_out[k*GRP_BITS +: GRP_BITS]),
            .grp_gen_o  (grp_g[k]),
            .grp_prop_o (grp_p[k])
        );
    end

    cla_lookahead #(.N(NGRP)) grp_la_i (
        .gen_i      (grp_g),
        .prop_i     (grp_p),
        .c0_i       (carry_in),
        .carry_o    (grp_c),
        .blk_gen_o  (top_g),
        .blk_prop_o (top_p)
    );

    assign carry_out = grp_c[NGRP];

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, carry_in})) begin
            // R1
            full_sum_chk: assert ({carry_out, sum_out} ==
                                  ({1'b0, opnd_a} + {1'b0, opnd_b} + (WIDTH+1)'(carry_in)))
                else $error("adder sum mismatch");
            // R2
            all_prop_chk: assert (!(top_p && carry_in) || carry_out)
                else $error("all-propagate carry lost");
            // R3
            top_gen_chk: assert (!top_g || carry_out)
                else $error("generated carry lost");
        end
    end

endmodule

// File: tb/cla_adder_tb_top.sv
module cla_adder_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic         ci  = 1'b0;
    logic [W-1:0] s;
    logic         co;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cla_adder #(.WIDTH(W)) dut_i (
        .opnd_a    (a),
        .opnd_b    (b),
        .carry_in  (ci),
        .sum_out   (s),
        .carry_out (co)
    );

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string req);
        logic [W:0] exp;
        @(negedge clk);
        a = x; b = y; ci = c;
        @(posedge clk);
        #1;
        exp = {1'b0, x} + {1'b0, y} + (W+1)'(c);
        checks++;
        if ({co, s} !== exp) begin
            errors++;
            $display("FAIL %s: %h+%h+%b got %h expected %h", req, x, y, c, {co, s}, exp);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr_a;
        logic [15:0] lfsr_b;
        lfsr_a = 16'hACE1;
        lfsr_b = 16'h1D2B;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // R5 reset-time idle state and zero operands
        apply(16'h0000, 16'h0000, 1'b0, "R5");
        apply(16'h0000, 16'h0000, 1'b1, "R5");
        // R2 all-propagate chain
        apply(16'hFFFF, 16'h0000, 1'b1, "R2");
        apply(16'hFFFF, 16'h0000, 1'b0, "R2");
        apply(16'h5555, 16'hAAAA, 1'b1, "R2");
        // R3 generate at bit 0
        apply(16'h0001, 16'hFFFF, 1'b0, "R3");
        // R4 carries crossing groups
        apply(16'h00F0, 16'h0010, 1'b0, "R4");
        apply(16'h0F00, 16'h0100, 1'b0, "R4");
        apply(16'h8000, 16'h8000, 1'b0, "R4");
        // R7 maximum operands
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R7");

        // R6 exhaustive per group, rest all-propagate then all-kill
        for (int k = 0; k < 4; k++) begin
            for (int bg = 0; bg < 2; bg++) begin
                for (int x = 0; x < 16; x++) begin
                    for (int y = 0; y < 16; y++) begin
                        for (int c = 0; c < 2; c++) begin
                            logic [W-1:0] base;
                            logic [W-1:0] xa;
                            logic [W-1:0] yb;
                            base = (bg == 0) ? 16'hFFFF : 16'h0000;
                            xa = base & ~(16'hF << (4*k));
                            xa = xa | (16'(x) << (4*k));
                            yb = (16'(y) << (4*k));
                            apply(xa, yb, c[0], "R6");
                        end
                    end
                end
            end
        end

        // R1 pseudo-random operands
        for (int n = 0; n < 20000; n++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
            apply(lfsr_a, lfsr_b ^ 16'(n), n[0], "R1");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule